// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache Controller

This block sits between a processor load/store port and a narrow backing memory. Every access comes with a virtual address and a translated physical address. It also carries two region attribute bits: `attrC` marks the region cacheable and `attrB` marks it bufferable. The cache has four ways. Each line holds eight 32-bit words, and the default size of 64 sets gives 8 KB. The set index and the compare tag are both taken from the virtual address. Each line also stores its physical line address, so a line can be written back without a translation lookup.

Cacheable bufferable regions use write-back with allocation. Cacheable regions that are not bufferable use write-through. Accesses to non-cacheable regions go straight to memory. On a refill the missed word is fetched first and the processor is released as soon as it arrives. The rest of the line is then fetched in wrap-around order. Each half of a line has its own dirty flag, and eviction writes back only the dirty halves.

A lock mask (one bit per way; a 1 means locked) keeps chosen ways from being replaced. Lines in locked ways can still hit. The replacement victim is chosen round-robin among the unlocked ways.

Top module: `dcache_wb`

## Requirements
- R1: After reset every line is invalid, `memReq` and `cpuDone` are low, and the first access to any cacheable address misses.
- R2: A load that hits (attrC=1) asserts `cpuDone` with the stored word in the same cycle it is presented, and issues no memory transfer.
- R3: A store that hits with attrC=1, attrB=1 updates the cached word and marks that half line dirty. It issues no memory write.
- R4: A store that hits with attrC=1, attrB=0 updates the cached word and also performs one memory write. It sets no dirty flag, so evicting that line later writes nothing back.
- R5: An access with attrC=0 is a single memory transfer at the physical address and leaves the cache unchanged. `memReq`, `memAddr` and `memWe` stay stable until `memAck`.
- R6: A refill reads words in the order k, k+1, …, wrapping modulo 8, where k is the missed word (virtual address bits [4:2]). `cpuDone` pulses with the first returned word.
- R7: Eviction writes back only the words of dirty halves. The lower half is words 0–3 and the upper half is words 4–7. The write address is formed from the line's stored physical line address.
- R8: All write-back transfers of a dirty victim finish before the first refill read of the new line.
- R9: New lines are placed only in ways whose `lockMask` bit is 0. Lines already held in locked ways still hit.
- R10: When all four `lockMask` bits are 1, a cacheable miss is served as one uncached memory transfer and nothing is allocated.
- R11: For each set, the victim is the first unlocked way at or after a per-set pointer. Allocating advances the pointer to the way after the victim, and the pointer is 0 after reset.
- R12: A store miss with attrC=1, attrB=0 performs one memory write and allocates no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Access request, held until `cpuDone` |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuVaddr | input | 32 | Virtual byte address (word aligned) |
| cpuPaddr | input | 32 | Physical byte address of the same access |
| cpuWdata | input | 32 | Store data |
| attrC | input | 1 | Region cacheable |
| attrB | input | 1 | Region bufferable (write-back when cacheable) |
| lockMask | input | 4 | Per-way lock, 1 = not allocatable |
| cpuDone | output | 1 | Access complete; load data valid |
| cpuRdata | output | 32 | Load data |
| memReq | output | 1 | Memory word transfer request |
| memWe | output | 1 | 1 = memory write |
| memAddr | output | 32 | Physical byte address of the transfer |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with `memAck` |
| memAck | input | 1 | Transfer accepted/completed this cycle |

## Verification
The hardest case to reach is the eviction of a line in which only one half is dirty. Reaching it needs the victim to be a specific way, that way to have been dirtied by a write-back store, and then a conflicting miss in the same set. The stimulus masks three ways so that only one can receive lines. It fills that way and dirties only its upper half. It then loads a second virtual tag that maps to the same set. The memory log must then show exactly four writes to the old physical line, followed by a wrapped refill of the new line. Round-robin order is shown by filling all four ways of one set and forcing a fifth line in. The bench then checks which of the old lines still hit.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

  typedef enum logic [1:0] {
    MS_CPU   = 2'd0,
    MS_EVICT = 2'd1,
    MS_FILL  = 2'd2
  } memSrc_t;

  typedef struct packed {
    logic    capture;
    logic    useLatched;
    logic    tagWrite;
    logic    validSet;
    logic    wordWrite;
    logic    useCpuData;
    logic    dirtySet;
    logic    rrAdvance;
    memSrc_t memSrc;
  } dpCtl_t;

endpackage

// File: rtl/dcache_dp.sv
module dcache_dp
  import dcache_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 64,
  parameter int LINE_WORDS = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpCtl_t                        ctl,
  input  logic [AW-1:0]                 cpuVaddr,
  input  logic [AW-1:0]                 cpuPaddr,
  input  logic [DW-1:0]                 cpuWdata,
  input  logic [DW-1:0]                 memRdata,
  input  logic [WAYS-1:0]               lockMask,
  input  logic [$clog2(WAYS)-1:0]       tgtWay,
  input  logic [$clog2(LINE_WORDS)-1:0] wordSel,
  output logic                          hit,
  output logic [$clog2(WAYS)-1:0]       hitWay,
  output logic [$clog2(WAYS)-1:0]       victimWay,
  output logic                          victimOk,
  output logic                          tgtValid,
  output logic [1:0]                    tgtDirty,
  output logic [$clog2(LINE_WORDS)-1:0] critWord,
  output logic [DW-1:0]                 arrayWord,
  output logic [AW-1:0]                 memAddr,
  output logic [DW-1:0]                 memWdata
);

  localparam int WAY_W  = $clog2(WAYS);
  localparam int WORD_W = $clog2(LINE_WORDS);
  localparam int SET_W  = $clog2(SETS);
  localparam int OFF_W  = WORD_W + 2;
  localparam int VTAG_W = AW - OFF_W - SET_W;
  localparam int PL_W   = AW - OFF_W;

  // request capture so a refill can outlive the CPU's request
  logic [AW-1:0] vaQ, paQ;
  logic [DW-1:0] wdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaQ <= '0;
      paQ <= '0;
      wdQ <= '0;
    end else if (ctl.capture) begin
      vaQ <= cpuVaddr;
      paQ <= cpuPaddr;
      wdQ <= cpuWdata;
    end
  end

  logic [AW-1:0]     va, pa;
  logic [DW-1:0]     wd;
  logic [SET_W-1:0]  setIdx;
  logic [VTAG_W-1:0] vtag;
  logic              unusedLowBits;

  assign va            = ctl.useLatched ? vaQ : cpuVaddr;
  assign pa            = ctl.useLatched ? paQ : cpuPaddr;
  assign wd            = ctl.useLatched ? wdQ : cpuWdata;
  assign setIdx        = va[OFF_W +: SET_W];
  assign vtag          = va[AW-1 -: VTAG_W];
  assign critWord      = va[2 +: WORD_W];
  assign unusedLowBits = ^va[1:0];

  // line state
  logic [VTAG_W-1:0] vtagQ  [SETS][WAYS];
  logic [PL_W-1:0]   plineQ [SETS][WAYS];
  logic [DW-1:0]     dataQ  [SETS][WAYS][LINE_WORDS];
  logic [WAYS-1:0]   validQ [SETS];
  logic [1:0]        dirtyQ [SETS][WAYS];
  logic [WAY_W-1:0]  rrQ    [SETS];

  // tag compare per way
  logic [WAYS-1:0] hitVec;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = validQ[setIdx][w] && (vtagQ[setIdx][w] == vtag);
  end

  always_comb begin
    hit    = |hitVec;
    hitWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hitVec[w]) hitWay = WAY_W'(w);
    end
  end

  // round-robin victim among unlocked ways; lowest distance from pointer wins
  always_comb begin
    logic [WAY_W-1:0] cand;
    victimOk  = 1'b0;
    victimWay = rrQ[setIdx];
    for (int k = WAYS - 1; k >= 0; k--) begin
      cand = rrQ[setIdx] + WAY_W'(k);
      if (!lockMask[cand]) begin
        victimOk  = 1'b1;
        victimWay = cand;
      end
    end
  end

  assign tgtValid  = validQ[setIdx][tgtWay];
  assign tgtDirty  = dirtyQ[setIdx][tgtWay];
  assign arrayWord = dataQ[setIdx][tgtWay][wordSel];

  always_comb begin
    case (ctl.memSrc)
      MS_EVICT: memAddr = {plineQ[setIdx][tgtWay], wordSel, 2'b00};
      MS_FILL:  memAddr = {pa[AW-1:OFF_W], wordSel, 2'b00};
      default:  memAddr = pa;
    endcase
    memWdata = (ctl.memSrc == MS_EVICT) ? arrayWord : wd;
  end

  // flags with reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validQ[s] <= '0;
        rrQ[s]    <= '0;
        for (int w = 0; w < WAYS; w++) dirtyQ[s][w] <= '0;
      end
    end else begin
      if (ctl.tagWrite) begin
        validQ[setIdx][tgtWay] <= 1'b0;
        dirtyQ[setIdx][tgtWay] <= 2'b00;
      end
      if (ctl.validSet) validQ[setIdx][tgtWay] <= 1'b1;
      if (ctl.dirtySet) dirtyQ[setIdx][tgtWay][wordSel[WORD_W-1]] <= 1'b1;
      if (ctl.rrAdvance) rrQ[setIdx] <= tgtWay + 1'b1;
    end
  end

  // tags and data, no reset needed
  always_ff @(posedge clk) begin
    if (ctl.tagWrite) begin
      vtagQ[setIdx][tgtWay]  <= vtag;
      plineQ[setIdx][tgtWay] <= pa[AW-1:OFF_W];
    end
    if (ctl.wordWrite)
      dataQ[setIdx][tgtWay][wordSel] <= ctl.useCpuData ? wd : memRdata;
  end

  // R9: allocation never targets a locked way
  p_alloc_unlocked_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.tagWrite |-> !lockMask[tgtWay]);

endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_pkg::*;
#(
  parameter int WAYS       = 4,
  parameter int LINE_WORDS = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cpuReq,
  input  logic                          cpuWe,
  input  logic                          attrC,
  input  logic                          attrB,
  input  logic                          hit,
  input  logic [$clog2(WAYS)-1:0]       hitWay,
  input  logic [$clog2(WAYS)-1:0]       victimWay,
  input  logic                          victimOk,
  input  logic                          tgtValid,
  input  logic [1:0]                    tgtDirty,
  input  logic [$clog2(LINE_WORDS)-1:0] critWord,
  input  logic                          memAck,
  output dpCtl_t                        ctl,
  output logic [$clog2(WAYS)-1:0]       tgtWay,
  output logic [$clog2(LINE_WORDS)-1:0] wordSel,
  output logic                          memReq,
  output logic                          memWe,
  output logic                          cpuDone,
  output logic                          rdFromMem
);

  localparam int WAY_W  = $clog2(WAYS);
  localparam int WORD_W = $clog2(LINE_WORDS);
  localparam logic [WORD_W-1:0] LAST      = WORD_W'(LINE_WORDS - 1);
  localparam logic [WORD_W-1:0] HALF_LAST = WORD_W'(LINE_WORDS / 2 - 1);
  localparam logic [WORD_W-1:0] HALF_1ST  = WORD_W'(LINE_WORDS / 2);

  typedef enum logic [1:0] {S_IDLE, S_UNC, S_EVICT, S_FILL} state_t;

  state_t            stateQ, stateD;
  logic [WAY_W-1:0]  wayQ, wayD;
  logic [WORD_W-1:0] cntQ, cntD;
  logic              weQ, weD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      wayQ   <= '0;
      cntQ   <= '0;
      weQ    <= 1'b0;
    end else begin
      stateQ <= stateD;
      wayQ   <= wayD;
      cntQ   <= cntD;
      weQ    <= weD;
    end
  end

  always_comb begin
    ctl            = '0;
    ctl.useLatched = 1'b1;
    ctl.memSrc     = MS_CPU;
    tgtWay         = wayQ;
    wordSel        = cntQ;
    memReq         = 1'b0;
    memWe          = 1'b0;
    cpuDone        = 1'b0;
    rdFromMem      = 1'b1;
    stateD         = stateQ;
    wayD           = wayQ;
    cntD           = cntQ;
    weD            = weQ;
    case (stateQ)
      S_IDLE: begin
        ctl.useLatched = 1'b0;
        rdFromMem      = 1'b0;
        tgtWay         = hit ? hitWay : victimWay;
        wordSel        = critWord;
        if (cpuReq) begin
          ctl.capture = 1'b1;
          weD         = cpuWe;
          if (!attrC || (!hit && ((cpuWe && !attrB) || !victimOk))) begin
            stateD = S_UNC;
          end else if (hit) begin
            cpuDone = !(cpuWe && !attrB);
            if (cpuWe) begin
              ctl.wordWrite  = 1'b1;
              ctl.useCpuData = 1'b1;
              ctl.dirtySet   = attrB;
              if (!attrB) stateD = S_UNC;
            end
          end else begin
            wayD          = victimWay;
            ctl.rrAdvance = 1'b1;
            if (tgtValid && |tgtDirty) begin
              stateD = S_EVICT;
              cntD   = tgtDirty[0] ? '0 : HALF_1ST;
            end else begin
              stateD       = S_FILL;
              cntD         = '0;
              ctl.tagWrite = 1'b1;
            end
          end
        end
      end
      S_UNC: begin
        memReq = 1'b1;
        memWe  = weQ;
        if (memAck) begin
          cpuDone = 1'b1;
          stateD  = S_IDLE;
        end
      end
      S_EVICT: begin
        memReq     = 1'b1;
        memWe      = 1'b1;
        ctl.memSrc = MS_EVICT;
        if (memAck) begin
          if (cntQ == LAST || (cntQ == HALF_LAST && !tgtDirty[1])) begin
            stateD       = S_FILL;
            cntD         = '0;
            ctl.tagWrite = 1'b1;
          end else begin
            cntD = cntQ + 1'b1;
          end
        end
      end
      default: begin
        wordSel    = critWord + cntQ;
        memReq     = 1'b1;
        ctl.memSrc = MS_FILL;
        if (memAck) begin
          ctl.wordWrite = 1'b1;
          if (cntQ == '0) begin
            cpuDone        = 1'b1;
            ctl.useCpuData = weQ;
            ctl.dirtySet   = weQ;
          end
          if (cntQ == LAST) begin
            ctl.validSet = 1'b1;
            stateD       = S_IDLE;
          end
          cntD = cntQ + 1'b1;
        end
      end
    endcase
  end

  // R6: each accepted refill word is followed by the next word of the wrap
  p_fill_wraps_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_FILL && memAck && cntQ != LAST) |=>
      (stateQ == S_FILL && wordSel == $past(wordSel) + 1'b1));

  // R8: a write-back sequence only ever continues or moves into refill
  p_evict_then_fill_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_EVICT) |=> (stateQ == S_EVICT || stateQ == S_FILL));

  // R10: an uncached transfer is exactly one word
  p_unc_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_UNC && memAck) |=> (stateQ == S_IDLE && !memReq));

endmodule

// File: rtl/dcache_wb.sv
module dcache_wb
  import dcache_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 64,
  parameter int LINE_WORDS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cpuReq,
  input  logic            cpuWe,
  input  logic [AW-1:0]   cpuVaddr,
  input  logic [AW-1:0]   cpuPaddr,
  input  logic [DW-1:0]   cpuWdata,
  input  logic            attrC,
  input  logic            attrB,
  input  logic [WAYS-1:0] lockMask,
  output logic            cpuDone,
  output logic [DW-1:0]   cpuRdata,
  output logic            memReq,
  output logic            memWe,
  output logic [AW-1:0]   memAddr,
  output logic [DW-1:0]   memWdata,
  input  logic [DW-1:0]   memRdata,
  input  logic            memAck
);

  localparam int WAY_W  = $clog2(WAYS);
  localparam int WORD_W = $clog2(LINE_WORDS);

  dpCtl_t            ctl;
  logic              hit, victimOk, tgtValid, rdFromMem;
  logic [WAY_W-1:0]  hitWay, victimWay, tgtWay;
  logic [1:0]        tgtDirty;
  logic [WORD_W-1:0] critWord, wordSel;
  logic [DW-1:0]     arrayWord;

  dcache_ctrl #(.WAYS(WAYS), .LINE_WORDS(LINE_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .attrC(attrC), .attrB(attrB), .hit(hit), .hitWay(hitWay),
    .victimWay(victimWay), .victimOk(victimOk), .tgtValid(tgtValid),
    .tgtDirty(tgtDirty), .critWord(critWord), .memAck(memAck),
    .ctl(ctl), .tgtWay(tgtWay), .wordSel(wordSel), .memReq(memReq),
    .memWe(memWe), .cpuDone(cpuDone), .rdFromMem(rdFromMem)
  );

  dcache_dp #(.AW(AW), .DW(DW), .WAYS(WAYS), .SETS(SETS),
              .LINE_WORDS(LINE_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cpuVaddr(cpuVaddr),
    .cpuPaddr(cpuPaddr), .cpuWdata(cpuWdata), .memRdata(memRdata),
    .lockMask(lockMask), .tgtWay(tgtWay), .wordSel(wordSel), .hit(hit),
    .hitWay(hitWay), .victimWay(victimWay), .victimOk(victimOk),
    .tgtValid(tgtValid), .tgtDirty(tgtDirty), .critWord(critWord),
    .arrayWord(arrayWord), .memAddr(memAddr), .memWdata(memWdata)
  );

  assign cpuRdata = rdFromMem ? memRdata : arrayWord;

  // R5: a memory transfer holds its address and direction until acknowledged
  p_mem_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

endmodule

// File: tb/tb_dcache_wb.sv
module tb_dcache_wb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0, cpuWe = 1'b0, attrC = 1'b0, attrB = 1'b0;
  logic [31:0] cpuVaddr = '0, cpuPaddr = '0, cpuWdata = '0;
  logic [3:0]  lockMask = '0;
  logic        cpuDone, memReq, memWe;
  logic [31:0] cpuRdata, memAddr, memWdata;
  logic [31:0] memRdata;
  logic        memAck;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dcache_wb dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .cpuVaddr(cpuVaddr), .cpuPaddr(cpuPaddr), .cpuWdata(cpuWdata),
    .attrC(attrC), .attrB(attrB), .lockMask(lockMask), .cpuDone(cpuDone),
    .cpuRdata(cpuRdata), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck)
  );

  function automatic logic [31:0] initWord(input logic [31:0] p);
    return {p[15:0] ^ 16'hA5A5, p[15:0]};
  endfunction

  // backing memory with one-cycle acknowledge and a transfer log
  logic [31:0] mem [4096];
  logic [31:0] logAddr [512];
  logic [31:0] logData [512];
  logic        logWe   [512];
  int          logN;

  initial for (int i = 0; i < 4096; i++) mem[i] = initWord(32'(i) << 2);

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAck   <= 1'b0;
      memRdata <= '0;
      logN     <= 0;
    end else begin
      memAck <= 1'b0;
      if (memReq && !memAck) begin
        memAck   <= 1'b1;
        memRdata <= mem[memAddr[13:2]];
        if (memWe) mem[memAddr[13:2]] <= memWdata;
        logAddr[logN[8:0]] <= memAddr;
        logData[logN[8:0]] <= memWdata;
        logWe[logN[8:0]]   <= memWe;
        logN <= logN + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    cpuReq = 1'b0;
    rstN   = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  int base;

  // one CPU access; doneOps = transfers seen when released, ops = total
  task automatic acc(input logic we, input logic [31:0] va, input logic [31:0] wd,
                     input logic [1:0] cb, output logic [31:0] rd,
                     output int doneOps, output int ops);
    @(negedge clk);
    base     = logN;
    cpuWe    = we;
    cpuVaddr = va;
    cpuPaddr = va ^ 32'h0000_2000;
    cpuWdata = wd;
    attrC    = cb[1];
    attrB    = cb[0];
    cpuReq   = 1'b1;
    forever begin
      #1;
      if (cpuDone) begin
        rd      = cpuRdata;
        doneOps = logN - base;
        @(posedge clk);
        #1 cpuReq = 1'b0;
        break;
      end
      @(negedge clk);
    end
    repeat (40) @(negedge clk);
    ops = logN - base;
  endtask

  typedef struct packed {
    logic        we;
    logic [31:0] va;
    logic [31:0] wd;
    logic [1:0]  cb;
    logic [31:0] exp;
    logic [7:0]  ops;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0104, 32'h0,         2'b11, 32'h84A1_2104, 8'd8}, // R1 cold miss, R6
    '{1'b0, 32'h0110, 32'h0,         2'b11, 32'h84B5_2110, 8'd0}, // R2 hit
    '{1'b1, 32'h0104, 32'hDEAD_0001, 2'b11, 32'h0,         8'd0}, // R3 wb store hit
    '{1'b0, 32'h0104, 32'h0,         2'b11, 32'hDEAD_0001, 8'd0}, // R3 readback
    '{1'b1, 32'h0108, 32'hBEEF_0002, 2'b10, 32'h0,         8'd1}, // R4 wt store hit
    '{1'b0, 32'h0108, 32'h0,         2'b10, 32'hBEEF_0002, 8'd0}, // R4 readback
    '{1'b0, 32'h0300, 32'h0,         2'b00, 32'h86A5_2300, 8'd1}, // R5 uncached
    '{1'b0, 32'h0300, 32'h0,         2'b00, 32'h86A5_2300, 8'd1}, // R5 not cached
    '{1'b1, 32'h0404, 32'h1234_5678, 2'b10, 32'h0,         8'd1}, // R12 wt store miss
    '{1'b0, 32'h0404, 32'h0,         2'b11, 32'h1234_5678, 8'd8}, // R12 no allocate
    '{1'b0, 32'h0108, 32'h0,         2'b11, 32'hBEEF_0002, 8'd0}  // R2 hit again
  };

  logic [31:0] rd;
  int dOps, ops;

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    #1;
    chk(memReq == 1'b0, "R1 memReq after reset", {31'd0, memReq}, 32'd0);
    chk(cpuDone == 1'b0, "R1 cpuDone after reset", {31'd0, cpuDone}, 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      acc(VECS[i].we, VECS[i].va, VECS[i].wd, VECS[i].cb, rd, dOps, ops);
      chk(ops == int'(VECS[i].ops), $sformatf("vec%0d R2/R3/R4/R5/R12 ops", i),
          32'(ops), 32'(VECS[i].ops));
      if (!VECS[i].we)
        chk(rd == VECS[i].exp, $sformatf("vec%0d R2/R5 data", i), rd, VECS[i].exp);
    end
    chk(mem[32'h2104 >> 2] == initWord(32'h2104), "R3 no memory write",
        mem[32'h2104 >> 2], initWord(32'h2104));
    chk(mem[32'h2108 >> 2] == 32'hBEEF_0002, "R4 write reached memory",
        mem[32'h2108 >> 2], 32'hBEEF_0002);

    // R1: reset invalidates previously cached line
    doReset();
    acc(1'b0, 32'h0104, 32'h0, 2'b11, rd, dOps, ops);
    chk(ops == 8, "R1 miss after reset", 32'(ops), 32'd8);

    // R6: critical word first and wrap order
    acc(1'b0, 32'h0A14, 32'h0, 2'b11, rd, dOps, ops);
    chk(dOps == 1, "R6 released on first word", 32'(dOps), 32'd1);
    chk(rd == initWord(32'h2A14), "R6 critical data", rd, initWord(32'h2A14));
    for (int k = 0; k < 8; k++)
      chk(logAddr[(base + k) % 512] == 32'h2A00 + 32'(((5 + k) % 8) * 4),
          "R6 wrap order", logAddr[(base + k) % 512],
          32'h2A00 + 32'(((5 + k) % 8) * 4));

    // R7/R8: only upper half dirty, single unlocked way
    lockMask = 4'b1110;
    acc(1'b0, 32'h0020, 32'h0, 2'b11, rd, dOps, ops);
    acc(1'b1, 32'h0034, 32'hCAFE_0005, 2'b11, rd, dOps, ops);
    acc(1'b0, 32'h0820, 32'h0, 2'b11, rd, dOps, ops);
    chk(ops == 12, "R7 half write-back count", 32'(ops), 32'd12);
    chk(dOps == 5, "R8 refill after write-back", 32'(dOps), 32'd5);
    for (int k = 0; k < 4; k++) begin
      chk(logWe[(base + k) % 512] == 1'b1, "R8 writes first",
          {31'd0, logWe[(base + k) % 512]}, 32'd1);
      chk(logAddr[(base + k) % 512] == 32'h2030 + 32'(k * 4), "R7 physical address",
          logAddr[(base + k) % 512], 32'h2030 + 32'(k * 4));
    end
    chk(logData[(base + 1) % 512] == 32'hCAFE_0005, "R7 dirty data",
        logData[(base + 1) % 512], 32'hCAFE_0005);
    chk(logWe[(base + 4) % 512] == 1'b0 && logAddr[(base + 4) % 512] == 32'h2820,
        "R8 refill start", logAddr[(base + 4) % 512], 32'h2820);

    // R4: write-through hit leaves line clean
    acc(1'b0, 32'h0040, 32'h0, 2'b11, rd, dOps, ops);
    acc(1'b1, 32'h0040, 32'h7777_0001, 2'b10, rd, dOps, ops);
    chk(ops == 1, "R4 single write", 32'(ops), 32'd1);
    acc(1'b0, 32'h0840, 32'h0, 2'b11, rd, dOps, ops);
    chk(ops == 8 && logWe[base % 512] == 1'b0, "R4 no write-back on evict",
        32'(ops), 32'd8);

    // R11/R9: round-robin in set 3
    doReset();
    lockMask = 4'b0000;
    acc(1'b0, 32'h0060, 32'h0, 2'b11, rd, dOps, ops);
    acc(1'b0, 32'h0860, 32'h0, 2'b11, rd, dOps, ops);
    acc(1'b0, 32'h1060, 32'h0, 2'b11, rd, dOps, ops);
    acc(1'b0, 32'h1860, 32'h0, 2'b11, rd, dOps, ops);
    acc(1'b0, 32'h0060, 32'h0, 2'b11, rd, dOps, ops);
    chk(ops == 0, "R11 four ways held", 32'(ops), 32'd0);
    acc(1'b0, 32'h2060, 32'h0, 2'b11, rd, dOps, ops);
    acc(1'b0, 32'h0860, 32'h0, 2'b11, rd, dOps, ops);
    chk(ops == 0, "R11 way1 kept", 32'(ops), 32'd0);
    acc(1'b0, 32'h1860, 32'h0, 2'b11, rd, dOps, ops);
    chk(ops == 0, "R11 way3 kept", 32'(ops), 32'd0);
    acc(1'b0, 32'h0060, 32'h0, 2'b11, rd, dOps, ops);
    chk(ops == 8, "R11 way0 was victim", 32'(ops), 32'd8);
    // now way0=2060 way1=0060 way2=1060 way3=1860, pointer at way2
    lockMask = 4'b0111;
    acc(1'b0, 32'h2860, 32'h0, 2'b11, rd, dOps, ops);
    chk(ops == 8, "R9 allocate into unlocked", 32'(ops), 32'd8);
    acc(1'b0, 32'h2060, 32'h0, 2'b11, rd, dOps, ops);
    chk(ops == 0 && rd == initWord(32'h0060), "R9 locked way hits", 32'(ops), 32'd0);
    acc(1'b0, 32'h1060, 32'h0, 2'b11, rd, dOps, ops);
    chk(ops == 0, "R9 locked way2 hits", 32'(ops), 32'd0);
    acc(1'b0, 32'h1860, 32'h0, 2'b11, rd, dOps, ops);
    chk(ops == 8, "R9 unlocked way replaced", 32'(ops), 32'd8);

    // R10: everything locked
    lockMask = 4'b1111;
    acc(1'b0, 32'h3060, 32'h0, 2'b11, rd, dOps, ops);
    chk(ops == 1 && rd == initWord(32'h1060), "R10 uncached load", rd,
        initWord(32'h1060));
    acc(1'b0, 32'h3060, 32'h0, 2'b11, rd, dOps, ops);
    chk(ops == 1, "R10 still not allocated", 32'(ops), 32'd1);
    acc(1'b1, 32'h3064, 32'h5555_AAAA, 2'b11, rd, dOps, ops);
    chk(ops == 1 && logWe[base % 512] == 1'b1, "R10 store goes to memory",
        32'(ops), 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule